// File: doc/BRIEF.md
# SDRAM Single-Bank Command and Data Sequencer

This block sits between a simple request port and one bank of a synchronous DRAM. A request names an operation: open a row, write a burst, write a burst with automatic precharge, or read a burst. It also carries a row or column address. The block issues that operation as a one-cycle command on the DRAM command lines. In every other cycle it issues NOP. For a write burst it drives the beats onto the data bus. For a read burst it captures the beats from the data bus once the programmed CAS latency has passed, and returns them with a valid strobe.

A read may be requested while a plain write burst is still running. The read then cuts the write short: the block releases the data bus in the same cycle that it issues the READ. When a write with automatic precharge finishes, the block times the data-to-precharge delay and the precharge time itself. It reports busy until the row may be opened again.

The data bus appears as separate output, output-enable and input lanes, so that the pad drivers can be placed outside the block. The CAS latency and the burst length are configuration inputs. They must stay stable while a burst is in flight.

Top module: `sdseq_top`

## Requirements
- R1: Synchronous active-high reset leaves `sd_cmd` at NOP (0), `dq_oe`, `busy`, `rd_valid` and `req_err` low, and the row closed.
- R2: `sd_cmd` is NOP (code 0) in every cycle except the one following a clock edge where a legal request was accepted.
- R3: The `req_op` codes are 0 open row, 1 write, 2 write with auto-precharge and 3 read. The `sd_cmd` codes are 0 NOP, 1 open row, 2 read, 3 write and 4 write with auto-precharge. An accepted legal request shows its command and `sd_addr` = `req_addr` in the next cycle. A read or write while no row is open, or an open-row request while a row is open, gives a one-cycle `req_err` pulse, and `sd_cmd` stays NOP.
- R4: A write accepted at edge E drives `dq_oe` high for BL cycles. BL is 2 when `cfg_bl4`=0 and 4 when it is 1. Beat k carries the `wr_data` value present at edge E+k, and `dq_oe` falls after edge E+BL.
- R5: A read issued at edge R captures `dq_in` at edges R+1+CL+k, for k = 0..BL-1. CL is `cfg_cas`, from 1 to 3. The captured beats appear on `rd_data` in order, with `rd_valid` high for exactly one cycle each.
- R6: A read accepted at edge E+t during a plain write burst started at edge E (1 ≤ t < BL) truncates the burst. Only t beats are driven, and `dq_oe` is low from the READ cycle on.
- R7: `dq_oe` is low in every cycle that carries a READ command, while a read is in flight, and whenever `rd_valid` is high.
- R8: For a write with auto-precharge whose last beat launches at edge L, the row closes at edge L+TDPL. `busy` stays high until edge L+TDPL+TRP-1, and an open-row request at edge L+TDPL+TRP is accepted.
- R9: While `busy` is high, requests are ignored: no command and no error. The only exception is a read that truncates a plain write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas | input | 2 | CAS latency in cycles (1..3) |
| cfg_bl4 | input | 1 | Burst length select: 0 gives 2 beats, 1 gives 4 beats |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Requested operation code |
| req_addr | input | ADDR_W | Row or column address |
| wr_data | input | DQ_W | Current write beat |
| busy | output | 1 | Requests are held off |
| req_err | output | 1 | Illegal request pulse |
| rd_data | output | DQ_W | Captured read beat |
| rd_valid | output | 1 | rd_data holds a new beat |
| sd_cmd | output | 3 | Encoded DRAM command |
| sd_addr | output | ADDR_W | DRAM address lines |
| dq_out | output | DQ_W | Data bus output lane |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | DQ_W | Data bus input lane |

## Verification
The bound assertions watch several properties on every cycle. They check that no command appears without a request on the prior edge, that an error never comes with a command, and that the bus is never driven while a READ is on the lines or a beat is captured. They also check that a write command always has the bus driven and that an open-row command is never issued while busy. Only the bench scenarios can show the exact capture edge for each CAS latency and burst length, the beat contents and their order, and the number of beats left after truncation at each possible point. The same holds for the precise cycle in which auto-precharge recovery ends and a new row may be opened.

// File: rtl/sdseq_pkg.sv
`timescale 1ns/1ps
package sdseq_pkg;

    localparam int MAX_CAS   = 3;
    localparam int MAX_BURST = 4;
    localparam int BEAT_W    = $clog2(MAX_BURST + 1);
    localparam int RDCNT_W   = $clog2(MAX_CAS + MAX_BURST + 1);

    typedef enum logic [1:0] {
        OP_OPEN  = 2'd0,
        OP_WR    = 2'd1,
        OP_WR_AP = 2'd2,
        OP_RD    = 2'd3
    } req_op_e;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_OPEN  = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_WR_AP = 3'd4
    } sd_cmd_e;

    typedef struct packed {
        logic open_row;
        logic wr;
        logic ap;
        logic rd;
        logic err;
    } dispatch_t;

    function automatic logic [BEAT_W-1:0] burst_beats(input logic long_burst);
        return long_burst ? BEAT_W'(4) : BEAT_W'(2);
    endfunction

    function automatic logic [1:0] cas_cycles(input logic [1:0] sel);
        return (sel == 2'd0) ? 2'd1 : sel;
    endfunction

endpackage

// File: rtl/sdseq_dispatch.sv
`timescale 1ns/1ps
module sdseq_dispatch
    import sdseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  req_op_e   op,
    input  logic      rd_active,
    input  logic      wr_active,
    input  logic      wr_ap,
    input  logic      tmr_active,
    input  logic      pre_start,
    output dispatch_t disp,
    output logic      busy
);

    logic row_open;
    logic trunc_ok;
    logic take;
    logic legal;

    assign busy     = rd_active | wr_active | tmr_active;
    assign trunc_ok = (op == OP_RD) && wr_active && !wr_ap && !rd_active && !tmr_active;
    assign take     = req_valid && (!busy || trunc_ok);
    assign legal    = (op == OP_OPEN) ? !row_open : row_open;

    always_comb begin
        disp          = '0;
        disp.err      = take && !legal;
        disp.open_row = take && legal && (op == OP_OPEN);
        disp.rd       = take && legal && (op == OP_RD);
        disp.wr       = take && legal && ((op == OP_WR) || (op == OP_WR_AP));
        disp.ap       = take && legal && (op == OP_WR_AP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
        end else if (disp.open_row) begin
            row_open <= 1'b1;
        end else if (pre_start) begin
            row_open <= 1'b0;
        end
    end

endmodule

// File: rtl/sdseq_wr_path.sv
`timescale 1ns/1ps
module sdseq_wr_path
    import sdseq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_ap,
    input  logic              stop,
    input  logic [BEAT_W-1:0] beats,
    input  logic [DQ_W-1:0]   wr_data,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              wr_active,
    output logic              wr_ap,
    output logic              ap_last
);

    logic [BEAT_W-1:0] left_q;

    assign wr_active = (left_q != '0);
    assign ap_last   = (left_q == BEAT_W'(1)) && wr_ap && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
            left_q <= '0;
            wr_ap  <= 1'b0;
        end else if (stop) begin
            dq_oe  <= 1'b0;
            left_q <= '0;
            wr_ap  <= 1'b0;
        end else if (start) begin
            dq_out <= wr_data;
            dq_oe  <= 1'b1;
            left_q <= beats - BEAT_W'(1);
            wr_ap  <= start_ap;
        end else if (left_q != '0) begin
            dq_out <= wr_data;
            left_q <= left_q - BEAT_W'(1);
        end else begin
            dq_oe  <= 1'b0;
            wr_ap  <= 1'b0;
        end
    end

endmodule

// File: rtl/sdseq_rd_capture.sv
`timescale 1ns/1ps
module sdseq_rd_capture
    import sdseq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [1:0]        cas,
    input  logic [BEAT_W-1:0] beats,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   rd_data,
    output logic              rd_valid,
    output logic              rd_active
);

    logic [RDCNT_W-1:0] cnt_q;
    logic [BEAT_W-1:0]  beats_q;
    logic               capture;

    assign rd_active = (cnt_q != '0);
    assign capture   = rd_active && (cnt_q <= RDCNT_W'(beats_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            beats_q <= '0;
        end else if (rd_start) begin
            cnt_q   <= RDCNT_W'(cas) + RDCNT_W'(beats);
            beats_q <= beats;
        end else if (rd_active) begin
            cnt_q   <= cnt_q - RDCNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sdseq_ap_timer.sv
`timescale 1ns/1ps
module sdseq_ap_timer #(
    parameter int TDPL = 2,
    parameter int TRP  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ap_last,
    output logic pre_start,
    output logic tmr_active
);

    localparam int DPL_W = $clog2(TDPL + 1);
    localparam int RP_W  = $clog2(TRP + 1);

    logic [DPL_W-1:0] dpl_q;
    logic [RP_W-1:0]  rp_q;

    assign pre_start  = (dpl_q == DPL_W'(1));
    assign tmr_active = (dpl_q != '0) || (rp_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dpl_q <= '0;
        end else if (ap_last) begin
            dpl_q <= DPL_W'(TDPL);
        end else if (dpl_q != '0) begin
            dpl_q <= dpl_q - DPL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q <= '0;
        end else if (pre_start) begin
            rp_q <= RP_W'(TRP - 1);
        end else if (rp_q != '0) begin
            rp_q <= rp_q - RP_W'(1);
        end
    end

endmodule

// File: rtl/sdseq_top.sv
`timescale 1ns/1ps
module sdseq_top
    import sdseq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DQ_W   = 16,
    parameter int TDPL   = 2,
    parameter int TRP    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_cas,
    input  logic              cfg_bl4,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   wr_data,
    output logic              busy,
    output logic              req_err,
    output logic [DQ_W-1:0]   rd_data,
    output logic              rd_valid,
    output logic [2:0]        sd_cmd,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in
);

    req_op_e           op;
    dispatch_t         disp;
    logic [BEAT_W-1:0] beats;
    logic [1:0]        cas;
    logic              rd_active;
    logic              wr_active;
    logic              wr_ap;
    logic              ap_last;
    logic              pre_start;
    logic              tmr_active;
    sd_cmd_e           cmd_q;

    assign op     = req_op_e'(req_op);
    assign beats  = burst_beats(cfg_bl4);
    assign cas    = cas_cycles(cfg_cas);
    assign sd_cmd = cmd_q;

    sdseq_dispatch u_dispatch (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .op         (op),
        .rd_active  (rd_active),
        .wr_active  (wr_active),
        .wr_ap      (wr_ap),
        .tmr_active (tmr_active),
        .pre_start  (pre_start),
        .disp       (disp),
        .busy       (busy)
    );

    sdseq_wr_path #(.DQ_W(DQ_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .start     (disp.wr),
        .start_ap  (disp.ap),
        .stop      (disp.rd),
        .beats     (beats),
        .wr_data   (wr_data),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .wr_active (wr_active),
        .wr_ap     (wr_ap),
        .ap_last   (ap_last)
    );

    sdseq_rd_capture #(.DQ_W(DQ_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_start  (disp.rd),
        .cas       (cas),
        .beats     (beats),
        .dq_in     (dq_in),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_active (rd_active)
    );

    sdseq_ap_timer #(.TDPL(TDPL), .TRP(TRP)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .ap_last    (ap_last),
        .pre_start  (pre_start),
        .tmr_active (tmr_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_NOP;
            sd_addr <= '0;
            req_err <= 1'b0;
        end else begin
            req_err <= disp.err;
            if (disp.open_row) begin
                cmd_q <= CMD_OPEN;
            end else if (disp.rd) begin
                cmd_q <= CMD_RD;
            end else if (disp.wr) begin
                cmd_q <= disp.ap ? CMD_WR_AP : CMD_WR;
            end else begin
                cmd_q <= CMD_NOP;
            end
            if (disp.open_row || disp.rd || disp.wr) begin
                sd_addr <= req_addr;
            end
        end
    end

endmodule

// File: rtl/sdseq_checker.sv
`timescale 1ns/1ps
module sdseq_checker
    import sdseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       req_err,
    input logic       rd_valid,
    input logic [2:0] sd_cmd,
    input logic       dq_oe
);

    AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd != CMD_NOP) |-> $past(req_valid)); // R2

    AST_ERR_WITHOUT_CMD: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (sd_cmd == CMD_NOP)); // R3

    AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        ((sd_cmd == CMD_WR) || (sd_cmd == CMD_WR_AP)) |-> dq_oe); // R4

    AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_RD) |-> !dq_oe); // R7

    AST_CAPTURE_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !dq_oe); // R7

    AST_OPEN_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_OPEN) |-> !$past(busy)); // R8

endmodule

bind sdseq_top sdseq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .req_err   (req_err),
    .rd_valid  (rd_valid),
    .sd_cmd    (sd_cmd),
    .dq_oe     (dq_oe)
);

// File: tb/sdseq_top_test.sv
`timescale 1ns/1ps
module sdseq_top_test;

    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int TDPL = 2;
    localparam int TRP  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_cas = 2'd1;
    logic          cfg_bl4 = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] dq_in = '0;
    logic          busy;
    logic          req_err;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [2:0]    sd_cmd;
    logic [AW-1:0] sd_addr;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int ecount = 0;
    int nchk   = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    sdseq_top #(.ADDR_W(AW), .DQ_W(DW), .TDPL(TDPL), .TRP(TRP)) uut (
        .clk(clk), .rst(rst), .cfg_cas(cfg_cas), .cfg_bl4(cfg_bl4),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .wr_data(wr_data), .busy(busy), .req_err(req_err),
        .rd_data(rd_data), .rd_valid(rd_valid), .sd_cmd(sd_cmd),
        .sd_addr(sd_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) ecount <= ecount + 1;

    function automatic logic [DW-1:0] wd(input int e);
        return DW'(e * 29 + 4660);
    endfunction

    function automatic logic [DW-1:0] dqv(input int e);
        return DW'(e * 53 + 2816);
    endfunction

    always @(negedge clk) begin
        wr_data <= wd(ecount + 1);
        dq_in   <= dqv(ecount + 1);
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h (edge %0d)", tag, got, exp, ecount);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        tick();
        req_valid = 1'b0;
    endtask

    // Read window starting at the negedge just after READ edge R
    task automatic rd_check(input int r, input int cl, input int bl, input bit poke);
        for (int j = 0; j <= cl + bl + 1; j++) begin
            bit vexp;
            vexp = (j >= cl + 1) && (j <= cl + bl);
            chk("R7 bus released during read", 32'(dq_oe), 32'd0);
            chk("R5 rd_valid strobe", 32'(rd_valid), 32'(vexp));
            if (vexp) chk("R5 read beat order/data", 32'(rd_data), 32'(dqv(r + j)));
            chk("R9 busy during read", 32'(busy), 32'(j < cl + bl));
            if (j >= 1) begin
                chk("R2 NOP between commands", 32'(sd_cmd), 32'd0);
                if (poke && j == 1) chk("R9 request ignored while busy", 32'(req_err), 32'd0);
            end
            if (poke && j == 0) begin
                req_valid = 1'b1; req_op = 2'd1; req_addr = 12'h0F0;
            end
            tick();
            req_valid = 1'b0;
        end
    endtask

    task automatic wr_check(input int trunc, input int cl, input int bl, input logic [AW-1:0] a);
        int e;
        int lim;
        string tag;
        tag = (trunc != 0) ? "R6" : "R4";
        issue(2'd1, a);
        e = ecount;
        chk("R3 write command", 32'(sd_cmd), 32'd3);
        chk("R3 write address", 32'(sd_addr), 32'(a));
        lim = (trunc != 0) ? trunc : bl;
        for (int k = 0; k < lim; k++) begin
            chk({tag, " write beat driven"}, 32'(dq_oe), 32'd1);
            chk({tag, " write beat data"}, 32'(dq_out), 32'(wd(e + k)));
            if (k > 0) chk("R2 NOP during burst", 32'(sd_cmd), 32'd0);
            if (trunc != 0 && k == trunc - 1) begin
                req_valid = 1'b1; req_op = 2'd3; req_addr = a + 12'd1;
            end
            tick();
            req_valid = 1'b0;
        end
        chk({tag, " bus released after burst"}, 32'(dq_oe), 32'd0);
        if (trunc != 0) begin
            chk("R6 truncating read issued", 32'(sd_cmd), 32'd2);
            rd_check(ecount, cl, bl, 1'b0);
        end
    endtask

    task automatic ap_check(input int bl);
        int e;
        int l;
        int stop;
        int poke;
        issue(2'd2, 12'h0A0);
        e = ecount;
        chk("R3 auto-precharge write command", 32'(sd_cmd), 32'd4);
        l = e + bl - 1;
        stop = l + TDPL + TRP - 1;
        poke = l + TDPL + 1;
        for (int n = e; n <= stop; n++) begin
            if (n - e < bl) begin
                chk("R4 ap write beat driven", 32'(dq_oe), 32'd1);
                chk("R4 ap write beat data", 32'(dq_out), 32'(wd(n)));
            end else begin
                chk("R4 ap bus released", 32'(dq_oe), 32'd0);
            end
            chk("R8 busy through precharge recovery", 32'(busy), 32'(n < stop));
            if (n == poke + 1) begin
                chk("R9 open ignored while recovering", 32'(sd_cmd), 32'd0);
                chk("R9 no error while recovering", 32'(req_err), 32'd0);
            end
            if (n == poke || n == stop) begin
                req_valid = 1'b1; req_op = 2'd0; req_addr = 12'h155;
            end
            tick();
            req_valid = 1'b0;
        end
        chk("R8 row reopened after recovery", 32'(sd_cmd), 32'd1);
        chk("R8 reopen without error", 32'(req_err), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        summary();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 reset cmd", 32'(sd_cmd), 32'd0);
        chk("R1 reset oe", 32'(dq_oe), 32'd0);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 reset err", 32'(req_err), 32'd0);
        tick();
        chk("R2 idle NOP", 32'(sd_cmd), 32'd0);

        issue(2'd3, 12'h010);
        chk("R1 row closed after reset: read errors", 32'(req_err), 32'd1);
        chk("R3 no command on error", 32'(sd_cmd), 32'd0);
        tick();
        chk("R3 error is one pulse", 32'(req_err), 32'd0);

        issue(2'd0, 12'h155);
        chk("R3 open command", 32'(sd_cmd), 32'd1);
        chk("R3 open address", 32'(sd_addr), 32'h155);
        chk("R3 open no error", 32'(req_err), 32'd0);
        issue(2'd0, 12'h0AA);
        chk("R3 open while open errors", 32'(req_err), 32'd1);
        chk("R3 open while open no command", 32'(sd_cmd), 32'd0);

        for (int cl = 1; cl <= 3; cl++) begin
            for (int b = 0; b < 2; b++) begin
                int bl;
                bl = (b != 0) ? 4 : 2;
                cfg_cas = 2'(cl);
                cfg_bl4 = b[0];
                tick();
                wr_check(0, cl, bl, 12'h020);
                issue(2'd3, 12'h040);
                chk("R5 read command", 32'(sd_cmd), 32'd2);
                chk("R5 read address", 32'(sd_addr), 32'h040);
                rd_check(ecount, cl, bl, 1'b1);
                for (int t = 1; t < bl; t++) begin
                    wr_check(t, cl, bl, 12'h060);
                end
                ap_check(bl);
            end
        end

        issue(2'd2, 12'h033);
        while (busy) tick();
        issue(2'd3, 12'h044);
        chk("R8 row closed by auto-precharge", 32'(req_err), 32'd1);
        chk("R8 no read on closed row", 32'(sd_cmd), 32'd0);

        summary();
    end

endmodule